// File: doc/BRIEF.md
# Thread Yield Qualifier Unit

This block decides what happens when a thread issues a yield request. The request carries a signed 32-bit descriptor, and the descriptor's value selects the action:

- **Zero** frees the thread's context.
- **Minus one** hands the processor to the scheduler while the thread stays eligible to run.
- **Minus two** only samples the qualifier inputs.
- **Any other negative value** is reserved and behaves like minus one.
- **A positive value** is a set of qualifier bits. The thread waits on those bits until one of them, enabled by the qualifier mask, goes high on the external qualifier inputs.

Illegal combinations raise a thread exception, and each case carries its own cause code.

Each accepted request produces a one-cycle pulse on the matching outputs at the clock edge after it is presented. The same applies to an exception, to a scheduler call and to a result write.

The result is the live qualifier inputs masked by the qualifier mask. It is written only to a nonzero destination index. For a waiting request it is taken at the moment the wait ends. While the thread waits, the unit ignores new requests, because a waiting thread cannot issue them.

Top module: `yield_qual_unit`

## Requirements
- R1: After reset every output is 0 and the unit is not waiting.
- R2: A zero descriptor while `peer_ready` is 1 pulses `dealloc` and `sched_call`, raises no exception, and writes the result if the destination is nonzero.
- R3: A zero descriptor while `peer_ready` is 0 raises an exception with cause 0, and gives no `dealloc`, no `sched_call` and no result.
- R4: A descriptor of -1, or any negative value other than -1 and -2, pulses `sched_call`, raises no exception, does not wait, and writes the result if the destination is nonzero.
- R5: A descriptor of -2 writes only the result: no `sched_call`, no exception, no `dealloc`, no wait.
- R6: A positive descriptor with any bit set that is not set in `qual_mask` (bit i of the descriptor pairs with bit i of the mask; bits at or above QW always count as unset) raises an exception with cause 2.
- R7: A legal positive descriptor pulses `sched_call` and sets `waiting` at the next edge. On the first later edge where `qual_in & qual_mask & descriptor` is nonzero, `waiting` clears and `wake` pulses for one cycle. Until then `waiting` stays 1.
- R8: When a request would call the scheduler and both `icpt_en` and `dbg_flag` are 1, it raises an exception with cause 4 instead. No `sched_call`, `dealloc` or wait follows.
- R9: Underflow (cause 0) and invalid qualifier (cause 2) take priority over the scheduler intercept (cause 4). `exc_cause` is 0 whenever `exc_valid` is 0.
- R10: When a request completes (at issue for non-waiting outcomes, at wake for waits), the unit outputs:
  - `res_valid` = 1 and `res_dst` = the request's destination, only when that destination is nonzero;
  - `res_data` = `qual_in & qual_mask` zero-extended, sampled in that cycle.
  
  At all other times `res_valid`, `res_dst` and `res_data` are 0.
- R11: While `waiting` is 1, `req_valid` has no effect: no exception, no `dealloc`, no `sched_call`, and no result except the one produced by the wake.
- R12: Every outcome appears at the clock edge that samples the request and lasts exactly one cycle. With `req_valid` low, every output pulse is 0 except for a wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Yield request present this cycle |
| req_desc | input | DW | Signed descriptor |
| req_dst | input | IW | Destination index for the result |
| qual_mask | input | QW | Enabled qualifier bits |
| qual_in | input | QW | External qualifier inputs |
| peer_ready | input | 1 | Some other context is allocatable, not halted and active |
| icpt_en | input | 1 | Scheduler intercept enable |
| dbg_flag | input | 1 | Per-thread debug flag |
| dealloc | output | 1 | Free the current context (pulse) |
| sched_call | output | 1 | Invoke the scheduler (pulse) |
| waiting | output | 1 | Thread waits on qualifiers |
| wake | output | 1 | Wait ended (pulse) |
| exc_valid | output | 1 | Thread exception (pulse) |
| exc_cause | output | 3 | Exception cause: 0 underflow, 2 invalid qualifier, 4 intercept |
| res_valid | output | 1 | Result write (pulse) |
| res_dst | output | IW | Result destination |
| res_data | output | DW | Masked qualifier inputs |

## Verification
The assertions assume that every input is a known two-state value at each sampling edge. They also assume that `req_desc`, `req_dst` and `qual_mask` describe the request in the cycle where `req_valid` is high.

The bench drives every input at the falling edge, so each value is settled well before the rising edge that samples it.

The stimulus has two parts:
- **Directed cycles** cover each descriptor class and each cause priority.
- **Random cycles** draw descriptors from every class, with masks that either contain or miss the descriptor bits. The qualifier inputs change randomly or stay at zero, so waits both end quickly and persist across issued requests.

// File: rtl/yield_qual_unit.sv
module yield_qual_unit #(
  parameter int QW = 31,
  parameter int DW = 32,
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [DW-1:0] req_desc,
  input  logic [IW-1:0] req_dst,
  input  logic [QW-1:0] qual_mask,
  input  logic [QW-1:0] qual_in,
  input  logic          peer_ready,
  input  logic          icpt_en,
  input  logic          dbg_flag,
  output logic          dealloc,
  output logic          sched_call,
  output logic          waiting,
  output logic          wake,
  output logic          exc_valid,
  output logic [2:0]    exc_cause,
  output logic          res_valid,
  output logic [IW-1:0] res_dst,
  output logic [DW-1:0] res_data
);

  localparam int PADW = DW - QW;
  localparam logic [DW-1:0] POLL_CODE = {{(DW-1){1'b1}}, 1'b0};
  localparam logic [2:0] CAUSE_UNDER = 3'd0;
  localparam logic [2:0] CAUSE_BADQ  = 3'd2;
  localparam logic [2:0] CAUSE_ICPT  = 3'd4;

  logic [QW-1:0] wait_q;
  logic [IW-1:0] dst_q;
  logic [QW-1:0] live;
  logic [DW-1:0] mask_ext;
  logic desc_zero, desc_neg, desc_poll, desc_pos, desc_bad;
  logic take, underflow, wants_sched, intercept, exc, ok, go_wait, hit;
  logic [2:0] cause;
  logic done_now;
  logic [IW-1:0] done_dst;

  assign live      = qual_in & qual_mask;
  assign mask_ext  = {{PADW{1'b0}}, qual_mask};
  assign desc_zero = (req_desc == '0);
  assign desc_neg  = req_desc[DW-1];
  assign desc_poll = (req_desc == POLL_CODE);
  assign desc_pos  = !desc_neg && !desc_zero;
  assign desc_bad  = desc_pos && |(req_desc & ~mask_ext);

  assign take        = req_valid && !waiting;
  assign underflow   = desc_zero && !peer_ready;
  assign wants_sched = !desc_poll && !underflow && !desc_bad;
  assign intercept   = wants_sched && icpt_en && dbg_flag;
  assign exc         = take && (underflow || desc_bad || intercept);
  assign cause       = underflow ? CAUSE_UNDER : (desc_bad ? CAUSE_BADQ : CAUSE_ICPT);
  assign ok          = take && !exc;
  assign go_wait     = ok && desc_pos;
  assign hit         = waiting && |(live & wait_q);

  assign done_now = hit ? (dst_q != '0) : (ok && !desc_pos && req_dst != '0);
  assign done_dst = hit ? dst_q : req_dst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dealloc    <= 1'b0;
      sched_call <= 1'b0;
      waiting    <= 1'b0;
      wake       <= 1'b0;
      exc_valid  <= 1'b0;
      exc_cause  <= '0;
      res_valid  <= 1'b0;
      res_dst    <= '0;
      res_data   <= '0;
      wait_q     <= '0;
      dst_q      <= '0;
    end else begin
      dealloc    <= ok && desc_zero;
      sched_call <= ok && !desc_poll;
      waiting    <= waiting ? !hit : go_wait;
      wake       <= hit;
      exc_valid  <= exc;
      exc_cause  <= exc ? cause : '0;
      res_valid  <= done_now;
      res_dst    <= done_now ? done_dst : '0;
      res_data   <= done_now ? {{PADW{1'b0}}, live} : '0;
      if (go_wait) begin
        wait_q <= req_desc[QW-1:0];
        dst_q  <= req_dst;
      end
    end
  end

  AST_UNDERFLOW_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !waiting && req_desc == '0 && !peer_ready) |=> (exc_valid && exc_cause == 3'd0)); // R3

  AST_POLL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !waiting && req_desc == POLL_CODE) |=> (!sched_call && !exc_valid && !dealloc && !waiting)); // R5

  AST_BAD_QUAL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !waiting && !req_desc[DW-1] && |(req_desc & ~mask_ext)) |=> (exc_valid && exc_cause == 3'd2)); // R6

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !(|(qual_in & qual_mask & wait_q))) |=> (waiting && !wake)); // R7

  AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> !waiting); // R7

  AST_EXC_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (!dealloc && !sched_call && !res_valid)); // R8

  AST_CAUSE_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_valid |-> (exc_cause == 3'd0)); // R9

  AST_RES_DST_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_dst != '0)); // R10

  AST_IGNORE_WHILE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && req_valid) |=> (!exc_valid && !dealloc && !sched_call)); // R11

endmodule

// File: tb/test_yield_qual_unit.sv
module test_yield_qual_unit;
  localparam int CLK_PERIOD = 10;
  localparam int QW = 31;
  localparam int DW = 32;
  localparam int IW = 5;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [DW-1:0] req_desc = '0;
  logic [IW-1:0] req_dst = '0;
  logic [QW-1:0] qual_mask = '0;
  logic [QW-1:0] qual_in = '0;
  logic peer_ready = 1'b0, icpt_en = 1'b0, dbg_flag = 1'b0;
  logic dealloc, sched_call, waiting, wake, exc_valid, res_valid;
  logic [2:0] exc_cause;
  logic [IW-1:0] res_dst;
  logic [DW-1:0] res_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  bit m_wait = 0;
  int m_bits = 0;
  int m_dst = 0;
  bit e_dealloc, e_sched, e_wait, e_wake, e_exc, e_rv;
  int e_cause, e_rdst, e_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  yield_qual_unit #(.QW(QW), .DW(DW), .IW(IW)) i_yield_qual_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_desc(req_desc),
    .req_dst(req_dst), .qual_mask(qual_mask), .qual_in(qual_in),
    .peer_ready(peer_ready), .icpt_en(icpt_en), .dbg_flag(dbg_flag),
    .dealloc(dealloc), .sched_call(sched_call), .waiting(waiting), .wake(wake),
    .exc_valid(exc_valid), .exc_cause(exc_cause), .res_valid(res_valid),
    .res_dst(res_dst), .res_data(res_data)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic compare_all();
    chk("R2 dealloc", int'(dealloc), int'(e_dealloc));
    chk("R4 sched_call", int'(sched_call), int'(e_sched));
    chk("R7 waiting", int'(waiting), int'(e_wait));
    chk("R7 wake", int'(wake), int'(e_wake));
    chk("R8 exc_valid", int'(exc_valid), int'(e_exc));
    chk("R9 exc_cause", int'(exc_cause), e_cause);
    chk("R10 res_valid", int'(res_valid), int'(e_rv));
    chk("R10 res_dst", int'(res_dst), e_rdst);
    chk("R10 res_data", int'(res_data), e_rdata);
  endtask

  task automatic model();
    int d, mk, live;
    bit bad, under, sched;
    d = int'(req_desc);
    mk = int'(qual_mask);
    live = int'(qual_in & qual_mask);
    e_dealloc = 0; e_sched = 0; e_wake = 0; e_exc = 0; e_rv = 0;
    e_cause = 0; e_rdst = 0; e_rdata = 0;
    if (m_wait) begin
      if ((live & m_bits) != 0) begin
        e_wake = 1;
        m_wait = 0;
        if (m_dst != 0) begin e_rv = 1; e_rdst = m_dst; e_rdata = live; end
      end
    end else if (req_valid) begin
      under = (d == 0) && !peer_ready;
      bad = (d > 0) && ((d & ~mk) != 0);
      sched = (d != -2) && !under && !bad;
      if (under) begin e_exc = 1; e_cause = 0; end
      else if (bad) begin e_exc = 1; e_cause = 2; end
      else if (sched && icpt_en && dbg_flag) begin e_exc = 1; e_cause = 4; end
      else begin
        if (d == 0) e_dealloc = 1;
        if (d != -2) e_sched = 1;
        if (d > 0) begin
          m_wait = 1; m_bits = d; m_dst = int'(req_dst);
        end else if (req_dst != 0) begin
          e_rv = 1; e_rdst = int'(req_dst); e_rdata = live;
        end
      end
    end
    e_wait = m_wait;
  endtask

  task automatic tick(input bit rv, input int d, input int dst, input int mk,
                      input int qin, input bit pr, input bit ie, input bit dbg);
    @(negedge clk);
    compare_all();
    req_valid = rv;
    req_desc = d;
    req_dst = dst[IW-1:0];
    qual_mask = mk[QW-1:0];
    qual_in = qin[QW-1:0];
    peer_ready = pr;
    icpt_en = ie;
    dbg_flag = dbg;
    model();
  endtask

  task automatic idle(input int mk, input int qin);
    tick(0, 0, 0, mk, qin, 1, 0, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    e_dealloc = 0; e_sched = 0; e_wait = 0; e_wake = 0; e_exc = 0; e_rv = 0;
    e_cause = 0; e_rdst = 0; e_rdata = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset waiting", int'(waiting), 0);
    chk("R1 reset exc_valid", int'(exc_valid), 0);
    chk("R1 reset res_valid", int'(res_valid), 0);
    rst_n = 1'b1;

    // R2 deallocate with an active peer
    tick(1, 0, 3, 'h0f, 'h05, 1, 0, 0);
    idle('h0f, 0);
    chk("R2 dealloc pulse", int'(dealloc), 1);
    chk("R2 result data", int'(res_data), 'h05);
    // R12 pulse lasts one cycle
    idle('h0f, 0);
    chk("R12 dealloc one cycle", int'(dealloc), 0);

    // R3 underflow
    tick(1, 0, 3, 'h0f, 'h05, 0, 0, 0);
    idle('h0f, 0);
    chk("R3 underflow exc", int'(exc_valid), 1);
    chk("R3 underflow cause", int'(exc_cause), 0);
    chk("R3 no dealloc", int'(dealloc), 0);

    // R4 -1 and a reserved negative
    tick(1, -1, 7, 'h3, 'h2, 1, 0, 0);
    idle('h3, 0);
    chk("R4 sched on -1", int'(sched_call), 1);
    tick(1, -77, 0, 'h3, 'h2, 1, 0, 0);
    idle('h3, 0);
    chk("R4 sched on reserved", int'(sched_call), 1);
    chk("R4 no exc on reserved", int'(exc_valid), 0);

    // R5 poll only
    tick(1, -2, 9, 'hff, 'h3c, 1, 1, 1);
    idle('hff, 0);
    chk("R5 poll no sched", int'(sched_call), 0);
    chk("R5 poll result", int'(res_data), 'h3c);
    chk("R5 poll no exc even with intercept", int'(exc_valid), 0);

    // R6 invalid qualifier, also wins over intercept (R9)
    tick(1, 'h30, 2, 'h10, 0, 1, 1, 1);
    idle('h10, 0);
    chk("R6 invalid cause", int'(exc_cause), 2);
    chk("R9 invalid over intercept", int'(exc_valid), 1);

    // R9 underflow over intercept
    tick(1, 0, 2, 'h10, 0, 0, 1, 1);
    idle('h10, 0);
    chk("R9 underflow over intercept", int'(exc_cause), 0);

    // R8 intercept on -1
    tick(1, -1, 2, 'h10, 0, 1, 1, 1);
    idle('h10, 0);
    chk("R8 intercept cause", int'(exc_cause), 4);
    chk("R8 intercept no sched", int'(sched_call), 0);

    // R7 wait, R11 requests ignored, then wake
    tick(1, 'h6, 4, 'hf, 'h1, 1, 0, 0);
    idle('hf, 'h1);
    chk("R7 waiting set", int'(waiting), 1);
    tick(1, 0, 5, 'hf, 'h8, 0, 0, 0);
    idle('hf, 'h8);
    chk("R11 ignored underflow", int'(exc_valid), 0);
    chk("R11 still waiting", int'(waiting), 1);
    idle('h3, 'h6);
    idle('h3, 0);
    chk("R7 wake pulse", int'(wake), 1);
    chk("R10 wake result", int'(res_data), 'h2);
    chk("R10 wake dst", int'(res_dst), 4);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      int sel, d, mk, qin;
      mk = int'($urandom) & 32'h7fffffff;
      if ($urandom % 3 == 0) mk = mk & 'hff;
      sel = int'($urandom % 6);
      case (sel)
        0: d = 0;
        1: d = -1;
        2: d = -2;
        3: d = -(3 + int'($urandom % 100));
        4: begin d = int'($urandom) & mk; if (d == 0) d = 1; end
        default: begin d = int'($urandom) & 32'h7fffffff; if (d == 0) d = 2; end
      endcase
      qin = ($urandom % 4 == 0) ? 0 : (int'($urandom) & 32'h7fffffff);
      tick($urandom % 2 == 1, d, int'($urandom % 32), mk, qin,
           $urandom % 4 != 0, $urandom % 3 == 0, $urandom % 3 == 0);
    end
    idle(0, 0);
    idle(0, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule